// File: doc/BRIEF.md
# Masked Lane Bit-Count Unit

This block treats a 512-bit operand as a row of independent lanes and produces one bit count per lane. The lanes are either sixteen 32-bit elements or eight 64-bit elements. Two counts are offered: the number of zero bits above the most significant set bit (leading-zero count), and the number of set bits (population count). Each count is written into its own lane, with zeros filling the bits above it.

A per-lane write mask decides which lanes take the new count. A lane whose mask bit is clear either becomes zero or takes the matching lane of a second input vector, depending on the policy select. An operation is accepted on any cycle where `in_valid` is high. Its result appears on the outputs one clock later, and it stays there until the next accepted operation.

Top module: `lane_bitcount_unit`

## Requirements
- R1: Each cycle with `in_valid` high produces `out_valid` high on the next cycle. A cycle with `in_valid` low produces `out_valid` low on the next cycle.
- R2: With `in_op`=1 (population count) and `in_wide`=0 (32-bit lanes), lane N (bits 32N+31..32N) holds the number of one bits in the same lane of `in_operand`.
- R3: With `in_op`=1 and `in_wide`=1 (64-bit lanes), lane N (bits 64N+63..64N) holds the number of one bits in that 64-bit lane, from 0 to 64.
- R4: With `in_op`=0 (leading-zero count) and `in_wide`=0, each 32-bit lane holds the count of zero bits above its highest set bit. An all-zero lane gives 32.
- R5: With `in_op`=0 and `in_wide`=1, each 64-bit lane holds its leading-zero count over all 64 bits. This count runs on into the lower half when the upper half is zero, and an all-zero lane gives 64.
- R6: Every count is zero-extended to the full lane width. No bit above the count's own width is ever set.
- R7: With `in_zero`=1, a lane whose mask bit is clear is written as all zeros.
- R8: With `in_zero`=0, a lane whose mask bit is clear is written with the same lane of `in_src`.
- R9: Mask bit N governs lane N. In 64-bit mode only `in_mask[7:0]` is used, and bits 15..8 have no effect on the result.
- R10: After reset `out_valid` is 0 and `out_data` is all zeros.
- R11: `out_data` holds its value through cycles with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| in_op | input | 1 | 0 = leading-zero count, 1 = population count |
| in_wide | input | 1 | 0 = sixteen 32-bit lanes, 1 = eight 64-bit lanes |
| in_mask | input | 16 | Write mask, bit N for lane N |
| in_zero | input | 1 | 1 = clear unselected lanes, 0 = merge from in_src |
| in_operand | input | 512 | Vector whose lanes are counted |
| in_src | input | 512 | Merge source for unselected lanes |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | Result vector |

## Verification
The assertions assume that the control inputs are known whenever `in_valid` is high. They also assume that lane 0 of a population-count result in 32-bit mode fits in six bits. This holds for any legal operand, because a 32-bit lane has at most 32 set bits. The bench changes inputs only on falling edges. It builds operands from per-lane patterns (all-zero, all-ones, random, and random shifted right) so that every legal lane value class and every count range is reached. It also drives bits 15..8 of the mask with random values in 64-bit mode to show that they are ignored.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
    localparam int NARROW_W = 32;
    localparam int N_NARROW = 16;
    localparam int VEC_W    = NARROW_W * N_NARROW;

    typedef enum logic {
        OP_LZC = 1'b0,
        OP_POP = 1'b1
    } lbc_op_e;
endpackage

// File: rtl/lbc_slice_count.sv
module lbc_slice_count #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] pop_cnt,
    output logic [CW-1:0] lz_cnt
);
    always_comb begin
        pop_cnt = '0;
        for (int i = 0; i < W; i++) begin
            pop_cnt = pop_cnt + CW'(bits[i]);
        end
    end

    always_comb begin
        logic seen;
        seen   = 1'b0;
        lz_cnt = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (bits[i]) seen = 1'b1;
                else         lz_cnt = lz_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lbc_lane_pair.sv
module lbc_lane_pair #(
    parameter int W   = 32,
    parameter int CW  = $clog2(W + 1),
    parameter int CW2 = $clog2(2 * W + 1)
) (
    input  logic [CW-1:0]  pop_lo,
    input  logic [CW-1:0]  pop_hi,
    input  logic [CW-1:0]  lz_lo,
    input  logic [CW-1:0]  lz_hi,
    output logic [CW2-1:0] pop_wide,
    output logic [CW2-1:0] lz_wide
);
    always_comb begin
        pop_wide = CW2'(pop_lo) + CW2'(pop_hi);
        if (lz_hi == CW'(W)) lz_wide = CW2'(W) + CW2'(lz_lo);
        else                 lz_wide = CW2'(lz_hi);
    end
endmodule

// File: rtl/lbc_lane_select.sv
module lbc_lane_select #(
    parameter int W        = 32,
    parameter int CW       = $clog2(W + 1),
    parameter int CW2      = $clog2(2 * W + 1),
    parameter bit IS_UPPER = 1'b0
) (
    input  logic           op_pop,
    input  logic           wide,
    input  logic           keep,
    input  logic           zero_mode,
    input  logic [CW-1:0]  pop_n,
    input  logic [CW-1:0]  lz_n,
    input  logic [CW2-1:0] pop_w,
    input  logic [CW2-1:0] lz_w,
    input  logic [W-1:0]   src,
    output logic [W-1:0]   result
);
    logic [CW2-1:0] cnt;

    always_comb begin
        if (wide) begin
            cnt = IS_UPPER ? '0 : (op_pop ? pop_w : lz_w);
        end else begin
            cnt = op_pop ? CW2'(pop_n) : CW2'(lz_n);
        end
        if (keep)           result = {{(W - CW2){1'b0}}, cnt};
        else if (zero_mode) result = '0;
        else                result = src;
    end
endmodule

// File: rtl/lane_bitcount_unit.sv
module lane_bitcount_unit
    import lbc_pkg::*;
#(
    parameter int LANE_W  = lbc_pkg::NARROW_W,
    parameter int N_LANES = lbc_pkg::N_NARROW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_op,
    input  logic                        in_wide,
    input  logic [15:0]                 in_mask,
    input  logic                        in_zero,
    input  logic [LANE_W*N_LANES-1:0]   in_operand,
    input  logic [LANE_W*N_LANES-1:0]   in_src,
    output logic                        out_valid,
    output logic [LANE_W*N_LANES-1:0]   out_data
);
    localparam int VW   = LANE_W * N_LANES;
    localparam int CW   = $clog2(LANE_W + 1);
    localparam int CW2  = $clog2(2 * LANE_W + 1);
    localparam int NW   = N_LANES / 2;

    typedef struct packed {
        logic          valid;
        logic [VW-1:0] data;
    } state_t;

    state_t state_d, state_q;

    logic [CW-1:0]  pop_n [N_LANES];
    logic [CW-1:0]  lz_n  [N_LANES];
    logic [CW2-1:0] pop_w [NW];
    logic [CW2-1:0] lz_w  [NW];
    logic [VW-1:0]  lane_vec;
    logic           op_pop;

    assign op_pop = (lbc_op_e'(in_op) == OP_POP);

    for (genvar s = 0; s < N_LANES; s++) begin : g_slice
        lbc_slice_count #(.W(LANE_W), .CW(CW)) u_cnt (
            .bits    (in_operand[s*LANE_W +: LANE_W]),
            .pop_cnt (pop_n[s]),
            .lz_cnt  (lz_n[s])
        );
    end

    for (genvar p = 0; p < NW; p++) begin : g_pair
        lbc_lane_pair #(.W(LANE_W), .CW(CW), .CW2(CW2)) u_pair (
            .pop_lo   (pop_n[2*p]),
            .pop_hi   (pop_n[2*p+1]),
            .lz_lo    (lz_n[2*p]),
            .lz_hi    (lz_n[2*p+1]),
            .pop_wide (pop_w[p]),
            .lz_wide  (lz_w[p])
        );
    end

    for (genvar s = 0; s < N_LANES; s++) begin : g_sel
        logic keep_bit;
        assign keep_bit = in_wide ? in_mask[s/2] : in_mask[s];
        lbc_lane_select #(
            .W(LANE_W), .CW(CW), .CW2(CW2), .IS_UPPER((s % 2) == 1)
        ) u_sel (
            .op_pop    (op_pop),
            .wide      (in_wide),
            .keep      (keep_bit),
            .zero_mode (in_zero),
            .pop_n     (pop_n[s]),
            .lz_n      (lz_n[s]),
            .pop_w     (pop_w[s/2]),
            .lz_w      (lz_w[s/2]),
            .src       (in_src[s*LANE_W +: LANE_W]),
            .result    (lane_vec[s*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) state_d.data = lane_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign out_data  = state_q.data;
endmodule

// File: rtl/lbc_checker.sv
module lbc_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_op,
    input logic         in_wide,
    input logic [15:0]  in_mask,
    input logic         in_zero,
    input logic [511:0] in_operand,
    input logic [511:0] in_src,
    input logic         out_valid,
    input logic [511:0] out_data
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    a_r7_zero_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_zero && !in_mask[0]) |=> (out_data[31:0] == 32'd0));
    a_r8_merge_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_zero && !in_mask[0] && !in_wide)
        |=> (out_data[31:0] == $past(in_src[31:0])));
    a_r6_pop_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op && !in_wide && in_mask[0])
        |=> (out_data[31:6] == 26'd0 && out_data[5:0] <= 6'd32));
    a_r5_wide_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_wide && in_mask[0]) |=> (out_data[63:7] == 57'd0));
endmodule

bind lane_bitcount_unit lbc_checker u_lbc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_wide    (in_wide),
    .in_mask    (in_mask),
    .in_zero    (in_zero),
    .in_operand (in_operand),
    .in_src     (in_src),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/tb_lane_bitcount_unit.sv
module tb_lane_bitcount_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_op = 1'b0;
    logic         in_wide = 1'b0;
    logic [15:0]  in_mask = '0;
    logic         in_zero = 1'b0;
    logic [511:0] in_operand = '0;
    logic [511:0] in_src = '0;
    logic         out_valid;
    logic [511:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lane_bitcount_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_mask(in_mask), .in_zero(in_zero),
        .in_operand(in_operand), .in_src(in_src),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [511:0] model(input logic op, input logic wide,
            input logic [15:0] mask, input logic zero,
            input logic [511:0] a, input logic [511:0] src);
        logic [511:0] r;
        int w;
        int n;
        r = '0;
        w = wide ? 64 : 32;
        n = wide ? 8 : 16;
        for (int l = 0; l < n; l++) begin
            int cnt;
            bit seen;
            cnt  = 0;
            seen = 1'b0;
            for (int b = w - 1; b >= 0; b--) begin
                if (op) cnt += int'(a[l*w + b]);
                else if (!seen) begin
                    if (a[l*w + b]) seen = 1'b1;
                    else cnt++;
                end
            end
            for (int b = 0; b < w; b++) begin
                if (mask[l])   r[l*w + b] = (b < 32) ? cnt[b] : 1'b0;
                else if (zero) r[l*w + b] = 1'b0;
                else           r[l*w + b] = src[l*w + b];
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [511:0] act,
                         input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic op, input logic wide,
            input logic [15:0] mask, input logic zero,
            input logic [511:0] a, input logic [511:0] src);
        logic [511:0] exp;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_wide = wide; in_mask = mask;
        in_zero = zero; in_operand = a; in_src = src;
        exp = model(op, wide, mask, zero, a, src);
        @(negedge clk);
        in_valid = 1'b0;
        in_operand = '0;
        check("R1 out_valid", {511'd0, out_valid}, 512'd1);
        check(tag, out_data, exp);
    endtask

    function automatic logic [511:0] rand_vec();
        logic [511:0] v;
        for (int s = 0; s < 16; s++) begin
            logic [31:0] x;
            case ($urandom % 4)
                0:       x = 32'd0;
                1:       x = $urandom;
                2:       x = $urandom >> ($urandom % 32);
                default: x = 32'hFFFF_FFFF;
            endcase
            v[s*32 +: 32] = x;
        end
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [511:0] held;
        void'($urandom(32'h1A2B_3C4D));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 out_valid", {511'd0, out_valid}, 512'd0);
        check("R10 out_data", out_data, 512'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op("R4 all-zero lanes give 32", 1'b0, 1'b0, 16'hFFFF, 1'b1, '0, '0);
        run_op("R5 all-zero lanes give 64", 1'b0, 1'b1, 16'h00FF, 1'b1, '0, '0);
        run_op("R5 lower half only", 1'b0, 1'b1, 16'h00FF, 1'b1, {8{64'h0000_0000_0000_0001}}, '0);
        run_op("R6 pop all ones 32", 1'b1, 1'b0, 16'hFFFF, 1'b1, {512{1'b1}}, '0);
        run_op("R3 pop all ones 64", 1'b1, 1'b1, 16'h00FF, 1'b1, {512{1'b1}}, '0);
        run_op("R6 lzc msb set", 1'b0, 1'b0, 16'hFFFF, 1'b0, {16{32'h8000_0000}}, {512{1'b1}});
        run_op("R7 all masked zeroed", 1'b1, 1'b0, 16'h0000, 1'b1, {512{1'b1}}, {512{1'b1}});
        run_op("R8 all masked merged", 1'b1, 1'b0, 16'h0000, 1'b0, {512{1'b1}}, {16{32'hA5A5_5A5A}});
        run_op("R9 upper mask bits ignored wide", 1'b1, 1'b1, 16'hFF00, 1'b0, {512{1'b1}}, {16{32'h1234_5678}});
        run_op("R9 lane0 only", 1'b0, 1'b0, 16'h0001, 1'b1, '0, '0);
        run_op("R9 alternate lanes", 1'b1, 1'b1, 16'hA5AA, 1'b0, rand_vec(), rand_vec());

        // R11: data holds while idle
        held = out_data;
        @(negedge clk);
        in_operand = rand_vec();
        @(negedge clk);
        check("R11 hold", out_data, held);
        check("R1 idle valid", {511'd0, out_valid}, 512'd0);

        for (int i = 0; i < 400; i++) begin
            logic op;
            logic wide;
            string tag;
            op   = 1'($urandom);
            wide = 1'($urandom);
            tag  = op ? (wide ? "R3 random" : "R2 random") : (wide ? "R5 random" : "R4 random");
            run_op(tag, op, wide, 16'($urandom), 1'($urandom), rand_vec(), rand_vec());
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule